// File: doc/BRIEF.md
# Crosspoint Parallel Command Decoder

This block is the control core of an 8x8 video routing matrix driven through a parallel command port. A host presents a 3-bit output address and a 4-bit command nibble. It then raises a write strobe while two chip enables are active, one high-true and one low-true. Route commands are staged in a first-rank register for each output. A second rank of registers drives the matrix. Copies from the first rank to the second happen on a latch pin, on a software latch command, or as a side effect of the buffer on/off commands.

The latch pin works in one of two modes, chosen by a mode input. In edge mode the second rank loads on each rising edge of the latch. In level mode the second rank follows the first rank for as long as the latch is low. The write strobe and the latch are asynchronous pins. Each passes through a two-flop synchronizer with an edge detector into the system clock domain, and every state change happens on that clock. For each output the block drives an input index, a ground flag and a buffer enable, all taken from the second rank.

Address and nibble must be held steady from the strobe rising edge for at least four clock cycles.

Top module: `xpt_cmd_decoder`

## Requirements
- R1: A write takes effect only while `ce_hi_i` is 1 and `ce_lo_n_i` is 0. A strobe outside that condition leaves all routing and enable state unchanged.
- R2: Nibble values 0..7 (bit 3 = 0) load the addressed output's first-rank route with input index nibble[2:0] and clear its ground flag.
- R3: Nibble 4'b1000 sets the addressed output's first-rank ground flag. Its stored index is kept.
- R4: Nibble 4'b1011 clears the enable of the addressed output and 4'b1100 sets it. Neither alters any stored route, and no other event sets an enable.
- R5: Nibble 4'b1101 clears every enable and 4'b1110 sets every enable.
- R6: Nibbles 4'b1011 to 4'b1110 also copy the whole first rank into the second rank in the same clock.
- R7: Nibble 4'b1111 copies the first rank into the second rank only when the synchronized latch is high. With the latch low it has no effect of its own.
- R8: With `edge_mode_i` = 1, the second rank changes only on a latch rising edge or through R6/R7. First-rank writes stay invisible at the outputs until then.
- R9: With `edge_mode_i` = 0, the second rank follows the first rank while the latch is low and holds while it is high.
- R10: Nibbles 4'b1001 and 4'b1010 change no routing, ground or enable state.
- R11: After reset every enable is 0. Stored routes read as index 0 with ground flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 3 | Target output for a command |
| nib_i | input | 4 | Command nibble |
| wr_i | input | 1 | Write strobe, acts on its rising edge |
| ce_hi_i | input | 1 | High-true chip enable |
| ce_lo_n_i | input | 1 | Low-true chip enable |
| latch_i | input | 1 | Rank transfer pin |
| edge_mode_i | input | 1 | 1 = edge-triggered latch, 0 = transparent-low latch |
| route_sel_o | output | 24 | Input index per output, output k at bits [3k+2:3k] |
| route_gnd_o | output | 8 | Ground select per output |
| buf_en_o | output | 8 | Buffer enable per output |

## Verification
Route and ground writes are issued with the latch held high in edge mode. This shows that the outputs come from the second rank and not from the command port. A following latch pulse shows that the staged value arrives. Buffer on/off commands are issued with the latch held, so the outputs change only through the command-driven transfer. The software latch is issued once with the latch high and once with it low, which separates a real copy from a silent no-op. Strobes with either enable wrong and the two reserved codes are each followed by a latch pulse, so any stray first-rank change would show at the outputs. Level mode is exercised with writes during low and during high latch to tell transparency from hold.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    // Control nibble values with bit 3 set; bit 3 clear is a route command.
    typedef enum logic [3:0] {
        OP_GND        = 4'b1000,
        OP_RSV_A      = 4'b1001,
        OP_RSV_B      = 4'b1010,
        OP_OFF_ONE    = 4'b1011,
        OP_ON_ONE     = 4'b1100,
        OP_OFF_ALL    = 4'b1101,
        OP_ON_ALL     = 4'b1110,
        OP_SOFT_LATCH = 4'b1111
    } xpt_op_e;

endpackage

// File: rtl/xpt_pin_sync.sv
module xpt_pin_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_edge
        assign lvl_o[g]  = st_q.sync[g];
        assign rise_o[g] = st_q.sync[g] & ~st_q.prev[g];
    end

endmodule

// File: rtl/xpt_cmd_decode.sv
module xpt_cmd_decode
    import xpt_pkg::*;
#(
    parameter int N_OUT  = 8,
    parameter int N_IN   = 8,
    parameter int ADDR_W = $clog2(N_OUT),
    parameter int SEL_W  = $clog2(N_IN)
) (
    input  logic              fire_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        nib_i,
    output logic [N_OUT-1:0]  tgt_o,
    output logic              route_wr_o,
    output logic              gnd_wr_o,
    output logic [SEL_W-1:0]  route_sel_o,
    output logic [N_OUT-1:0]  en_clr_o,
    output logic [N_OUT-1:0]  en_set_o,
    output logic              rank_xfer_o,
    output logic              soft_latch_o
);

    logic [N_OUT-1:0] hit;
    logic             route_ok;

    for (genvar g = 0; g < N_OUT; g++) begin : g_hit
        assign hit[g] = (addr_i == ADDR_W'(g));
    end

    if (N_IN >= 8) begin : g_full_in
        assign route_ok = 1'b1;
    end else begin : g_part_in
        assign route_ok = ({1'b0, nib_i[2:0]} < 4'(N_IN));
    end

    always_comb begin
        tgt_o        = '0;
        route_wr_o   = 1'b0;
        gnd_wr_o     = 1'b0;
        en_clr_o     = '0;
        en_set_o     = '0;
        rank_xfer_o  = 1'b0;
        soft_latch_o = 1'b0;
        route_sel_o  = nib_i[SEL_W-1:0];
        if (fire_i) begin
            if (!nib_i[3]) begin
                route_wr_o = route_ok;
                tgt_o      = hit;
            end else begin
                case (nib_i)
                    OP_GND: begin
                        gnd_wr_o = 1'b1;
                        tgt_o    = hit;
                    end
                    OP_OFF_ONE: begin
                        en_clr_o    = hit;
                        rank_xfer_o = 1'b1;
                    end
                    OP_ON_ONE: begin
                        en_set_o    = hit;
                        rank_xfer_o = 1'b1;
                    end
                    OP_OFF_ALL: begin
                        en_clr_o    = '1;
                        rank_xfer_o = 1'b1;
                    end
                    OP_ON_ALL: begin
                        en_set_o    = '1;
                        rank_xfer_o = 1'b1;
                    end
                    OP_SOFT_LATCH: soft_latch_o = 1'b1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/xpt_rank_store.sv
module xpt_rank_store #(
    parameter int N_OUT = 8,
    parameter int SEL_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_OUT-1:0]             tgt_i,
    input  logic                         route_wr_i,
    input  logic                         gnd_wr_i,
    input  logic [SEL_W-1:0]             route_sel_i,
    input  logic [N_OUT-1:0]             en_clr_i,
    input  logic [N_OUT-1:0]             en_set_i,
    input  logic                         rank_xfer_i,
    input  logic                         soft_latch_i,
    input  logic                         latch_lvl_i,
    input  logic                         latch_rise_i,
    input  logic                         edge_mode_i,
    output logic [N_OUT-1:0][SEL_W-1:0]  sel_o,
    output logic [N_OUT-1:0]             gnd_o,
    output logic [N_OUT-1:0]             en_o
);

    typedef struct packed {
        logic [N_OUT-1:0][SEL_W-1:0] f_sel;
        logic [N_OUT-1:0]            f_gnd;
        logic [N_OUT-1:0][SEL_W-1:0] s_sel;
        logic [N_OUT-1:0]            s_gnd;
        logic [N_OUT-1:0]            en;
    } rank_t;

    rank_t st_d, st_q;
    logic  copy;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_OUT; i++) begin
            if (tgt_i[i] && route_wr_i) begin
                st_d.f_sel[i] = route_sel_i;
                st_d.f_gnd[i] = 1'b0;
            end
            if (tgt_i[i] && gnd_wr_i) begin
                st_d.f_gnd[i] = 1'b1;
            end
        end
        copy = rank_xfer_i
             | (soft_latch_i & latch_lvl_i)
             | (edge_mode_i ? latch_rise_i : ~latch_lvl_i);
        if (copy) begin
            st_d.s_sel = st_d.f_sel;
            st_d.s_gnd = st_d.f_gnd;
        end
        st_d.en = (st_q.en & ~en_clr_i) | en_set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o = st_q.s_sel;
    assign gnd_o = st_q.s_gnd;
    assign en_o  = st_q.en;

    // R8: in edge mode, no rising edge and no command transfer keeps the second rank
    a_r8_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && !latch_rise_i && !rank_xfer_i && !(soft_latch_i && latch_lvl_i))
        |=> ($stable(st_q.s_sel) && $stable(st_q.s_gnd)));

    // R9: in level mode with the latch high and no command transfer the second rank holds
    a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode_i && latch_lvl_i && !rank_xfer_i && !soft_latch_i)
        |=> ($stable(st_q.s_sel) && $stable(st_q.s_gnd)));

    // R6: a buffer on/off command leaves the two ranks equal
    a_r6_xfer_match: assert property (@(posedge clk) disable iff (!rst_n)
        rank_xfer_i |=> (st_q.s_sel == st_q.f_sel && st_q.s_gnd == st_q.f_gnd));

    // R4: an enable bit rises only when a set request was present
    a_r4_no_stray_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_i == '0) |=> ((st_q.en & ~$past(st_q.en)) == '0));

endmodule

// File: rtl/xpt_cmd_decoder.sv
module xpt_cmd_decoder #(
    parameter int N_OUT  = 8,
    parameter int N_IN   = 8,
    localparam int ADDR_W = $clog2(N_OUT),
    localparam int SEL_W  = $clog2(N_IN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [3:0]               nib_i,
    input  logic                     wr_i,
    input  logic                     ce_hi_i,
    input  logic                     ce_lo_n_i,
    input  logic                     latch_i,
    input  logic                     edge_mode_i,
    output logic [N_OUT*SEL_W-1:0]   route_sel_o,
    output logic [N_OUT-1:0]         route_gnd_o,
    output logic [N_OUT-1:0]         buf_en_o
);

    localparam int PIN_STB = 0;
    localparam int PIN_LAT = 1;

    logic [1:0]                  pins, lvl, rise;
    logic                        fire;
    logic [N_OUT-1:0]            tgt, en_clr, en_set;
    logic                        route_wr, gnd_wr, rank_xfer, soft_latch;
    logic [SEL_W-1:0]            dec_sel;
    logic [N_OUT-1:0][SEL_W-1:0] sel_arr;

    assign pins[PIN_STB] = wr_i & ce_hi_i & ~ce_lo_n_i;
    assign pins[PIN_LAT] = latch_i;

    xpt_pin_sync #(.W(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pins),
        .lvl_o  (lvl),
        .rise_o (rise)
    );

    assign fire = rise[PIN_STB] & lvl[PIN_STB];

    xpt_cmd_decode #(.N_OUT(N_OUT), .N_IN(N_IN), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dec (
        .fire_i       (fire),
        .addr_i       (addr_i),
        .nib_i        (nib_i),
        .tgt_o        (tgt),
        .route_wr_o   (route_wr),
        .gnd_wr_o     (gnd_wr),
        .route_sel_o  (dec_sel),
        .en_clr_o     (en_clr),
        .en_set_o     (en_set),
        .rank_xfer_o  (rank_xfer),
        .soft_latch_o (soft_latch)
    );

    xpt_rank_store #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .tgt_i        (tgt),
        .route_wr_i   (route_wr),
        .gnd_wr_i     (gnd_wr),
        .route_sel_i  (dec_sel),
        .en_clr_i     (en_clr),
        .en_set_i     (en_set),
        .rank_xfer_i  (rank_xfer),
        .soft_latch_i (soft_latch),
        .latch_lvl_i  (lvl[PIN_LAT]),
        .latch_rise_i (rise[PIN_LAT]),
        .edge_mode_i  (edge_mode_i),
        .sel_o        (sel_arr),
        .gnd_o        (route_gnd_o),
        .en_o         (buf_en_o)
    );

    assign route_sel_o = sel_arr;

    // R10: a reserved nibble in edge mode without a latch edge leaves every output alone
    a_r10_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (nib_i == 4'b1001 || nib_i == 4'b1010) && edge_mode_i && !rise[PIN_LAT])
        |=> ($stable(route_sel_o) && $stable(route_gnd_o) && $stable(buf_en_o)));

    // R1: a strobe blocked by the enables never starts a command
    a_r1_gated_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_hi_i || ce_lo_n_i) |=> !u_sync.st_q.meta[PIN_STB]);

endmodule

// File: tb/tb_xpt_cmd_decoder.sv
module tb_xpt_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [3:0]  nib = '0;
    logic        wr = 1'b0, ce_hi = 1'b1, ce_lo_n = 1'b0;
    logic        latch = 1'b1, edge_mode = 1'b1;
    logic [23:0] route_sel;
    logic [7:0]  route_gnd, buf_en;

    always #10 clk = ~clk;

    xpt_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .nib_i(nib), .wr_i(wr),
        .ce_hi_i(ce_hi), .ce_lo_n_i(ce_lo_n), .latch_i(latch),
        .edge_mode_i(edge_mode), .route_sel_o(route_sel),
        .route_gnd_o(route_gnd), .buf_en_o(buf_en)
    );

    typedef struct {
        logic [23:0] sel;
        logic [7:0]  gnd;
        logic [7:0]  en;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0, failures = 0;
    bit   done = 1'b0;

    logic [2:0] f_sel [8];
    logic [7:0] f_gnd, s_gnd, m_en;
    logic [2:0] s_sel [8];

    task automatic copy_ranks();
        for (int i = 0; i < 8; i++) s_sel[i] = f_sel[i];
        s_gnd = f_gnd;
    endtask

    task automatic expect_now(string tag);
        exp_t e;
        for (int i = 0; i < 8; i++) e.sel[i*3 +: 3] = s_sel[i];
        e.gnd = s_gnd;
        e.en  = m_en;
        e.tag = tag;
        q.push_back(e);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] a, input logic [3:0] n,
                       input logic chi, input logic clon);
        @(negedge clk);
        addr = a; nib = n; ce_hi = chi; ce_lo_n = clon;
        @(negedge clk);
        wr = 1'b1;
        repeat (6) @(negedge clk);
        wr = 1'b0;
        repeat (4) @(negedge clk);
        ce_hi = 1'b1; ce_lo_n = 1'b0;
        if (chi && !clon) begin
            if (!n[3]) begin f_sel[a] = n[2:0]; f_gnd[a] = 1'b0; end
            else case (n)
                4'b1000: f_gnd[a] = 1'b1;
                4'b1011: begin m_en[a] = 1'b0; copy_ranks(); end
                4'b1100: begin m_en[a] = 1'b1; copy_ranks(); end
                4'b1101: begin m_en = '0; copy_ranks(); end
                4'b1110: begin m_en = '1; copy_ranks(); end
                4'b1111: if (latch) copy_ranks();
                default: ;
            endcase
            if (!edge_mode && !latch) copy_ranks();
        end
    endtask

    task automatic set_latch(input logic v);
        logic old;
        old = latch;
        @(negedge clk);
        latch = v;
        repeat (6) @(negedge clk);
        if (edge_mode && v && !old) copy_ranks();
        if (!edge_mode && !v) copy_ranks();
    endtask

    task automatic pulse_latch();
        set_latch(1'b0);
        set_latch(1'b1);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (route_sel !== e.sel || route_gnd !== e.gnd || buf_en !== e.en) begin
                    failures++;
                    $display("FAIL %s: actual sel=%h gnd=%h en=%h expected sel=%h gnd=%h en=%h",
                             e.tag, route_sel, route_gnd, buf_en, e.sel, e.gnd, e.en);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 8; i++) begin f_sel[i] = '0; s_sel[i] = '0; end
        f_gnd = '0; s_gnd = '0; m_en = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        expect_now("R11");                      // reset: enables off, routes zero

        cmd(3'd3, 4'd5, 1'b1, 1'b0);
        expect_now("R8");                       // staged only, latch held
        pulse_latch();
        expect_now("R2");                       // out3 <- input 5
        cmd(3'd1, 4'd7, 1'b1, 1'b0);
        cmd(3'd1, 4'd2, 1'b1, 1'b0);
        pulse_latch();
        expect_now("R2");                       // last write wins

        cmd(3'd0, 4'b1110, 1'b1, 1'b0);
        expect_now("R5");                       // all on
        cmd(3'd0, 4'b1000, 1'b1, 1'b0);
        expect_now("R8");
        pulse_latch();
        expect_now("R3");                       // out0 grounded

        cmd(3'd3, 4'b1011, 1'b1, 1'b0);
        expect_now("R4");                       // out3 off, route kept
        cmd(3'd3, 4'b1100, 1'b1, 1'b0);
        expect_now("R4");                       // out3 on again

        cmd(3'd4, 4'd7, 1'b0, 1'b0);
        cmd(3'd4, 4'd6, 1'b1, 1'b1);
        pulse_latch();
        expect_now("R1");                       // gated writes ignored

        cmd(3'd2, 4'b1001, 1'b1, 1'b0);
        cmd(3'd2, 4'b1010, 1'b1, 1'b0);
        expect_now("R10");
        pulse_latch();
        expect_now("R10");

        cmd(3'd6, 4'd2, 1'b1, 1'b0);
        cmd(3'd0, 4'b1111, 1'b1, 1'b0);
        expect_now("R7");                       // soft latch with latch high copies
        set_latch(1'b0);
        cmd(3'd6, 4'd4, 1'b1, 1'b0);
        cmd(3'd0, 4'b1111, 1'b1, 1'b0);
        expect_now("R7");                       // soft latch with latch low: no copy
        set_latch(1'b1);
        expect_now("R8");                       // rising edge copies

        cmd(3'd0, 4'b1101, 1'b1, 1'b0);
        expect_now("R5");                       // all off

        @(negedge clk);
        edge_mode = 1'b0;
        repeat (3) @(negedge clk);
        cmd(3'd7, 4'd1, 1'b1, 1'b0);
        expect_now("R9");                       // held while high
        set_latch(1'b0);
        expect_now("R9");                       // transparent on low
        cmd(3'd7, 4'd3, 1'b1, 1'b0);
        expect_now("R9");                       // follows while low
        set_latch(1'b1);
        cmd(3'd7, 4'd6, 1'b1, 1'b0);
        expect_now("R9");                       // held again

        cmd(3'd5, 4'd4, 1'b1, 1'b0);
        expect_now("R9");
        cmd(3'd5, 4'b1100, 1'b1, 1'b0);
        expect_now("R6");                       // on-command pulls first rank over

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule